// File: doc/BRIEF.md
# Interrupt Cause Aggregator with Doorbell

This block collects 64 interrupt numbers into one top-level interrupt line. Twenty-one of them are driven by synchronous level-high wires. Any of the 64 can also be raised by a message write to a doorbell register, where the write data is the interrupt number. Each number has a sticky cause bit and a mask bit. The output line is high while at least one cause bit is pending and not masked.

A simple register bus reaches the block. It has a write strobe, a byte address and 32-bit write data, and read data that follows the address combinationally. Software handles the line in four steps. It reads the two cause words, lowest word first. It serves the set bits. It acknowledges each one by writing a 1 to that bit. It masks or unmasks a source by rewriting the whole mask word.

The block has no sequencing state machine. Each cause bit moves between two named states, IDLE and PENDING. The transition SET (level wire high, or a doorbell hit) takes a bit from IDLE to PENDING. The transition ACK (write-one-to-clear) takes it from PENDING to IDLE.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset, both cause words read 0, both mask words read 0xFFFFFFFF, and irq_out is low.
- R2: Interrupt n lives in word n/32 at bit n%32. The cause words are at byte addresses 0x00 and 0x04, the mask words at 0x20 and 0x24, and the doorbell at 0x30. A write to any other address changes nothing. A read of any other address, or of the doorbell, returns 0.
- R3: A mask bit of 1 blocks its interrupt from irq_out and a mask bit of 0 lets it through. A mask write replaces the whole word, and the new value reads back after the write edge.
- R4: A write to a cause word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A pending cause bit stays set until it is acknowledged, whether or not it is masked. Unmasking it later raises irq_out.
- R6: A doorbell write with data n below 64 sets cause bit n at the write edge. A doorbell write with data of 64 or more changes no state.
- R7: While level wire k (k from 0 to 20) is high, cause bit k is set. If it is acknowledged while the wire is still high, it reads 0 for one cycle and is set again at the next edge.
- R8: irq_out is high exactly when some cause bit in either word is set and its mask bit is 0. It follows the register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address and data |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data; the interrupt number for the doorbell |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lvl_src | input | 21 | Level-high wired sources for interrupts 0 to 20 |
| irq_out | output | 1 | Top-level interrupt, high while any unmasked cause is pending |

## Verification
A cause or mask bit that is stuck or misplaced shows up at the next read of its word, one cycle after the write that should have moved it. The same fault shows on irq_out as soon as the matching mask bit is opened. The bench therefore sweeps every one of the 64 numbers through doorbell, readback, unmask and acknowledge, and checks the exact word and bit each time. A wrong priority between acknowledge and a level wire shows as a missing one-cycle dip in the readback, or as a bit that never returns.

// File: rtl/agg_pkg.sv
package agg_pkg;

    // Kind of register an address selects
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CAUSE,
        ACC_MASK,
        ACC_DOORBELL
    } acc_kind_e;

    // Byte addresses; software and the decoder both depend on these
    localparam int CAUSE_BASE    = 'h00;
    localparam int MASK_BASE     = 'h20;
    localparam int DOORBELL_ADDR = 'h30;
    localparam int WORD_BYTES    = 4;

endpackage

// File: rtl/agg_regdecode.sv
module agg_regdecode
    import agg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_IRQ  = 64,
    parameter int NUM_REGS = NUM_IRQ / DATA_W
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output acc_kind_e           kind,
    output logic [NUM_REGS-1:0] reg_sel,
    output logic [NUM_IRQ-1:0]  db_set
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    // Address match: which word, and which kind of word
    always_comb begin
        kind    = ACC_NONE;
        reg_sel = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(CAUSE_BASE + WORD_BYTES * r)) begin
                kind       = ACC_CAUSE;
                reg_sel[r] = 1'b1;
            end
            if (addr == ADDR_W'(MASK_BASE + WORD_BYTES * r)) begin
                kind       = ACC_MASK;
                reg_sel[r] = 1'b1;
            end
        end
        if (addr == ADDR_W'(DOORBELL_ADDR)) begin
            kind = ACC_DOORBELL;
        end
    end

    // Doorbell: data is the absolute interrupt number; out of range is dropped
    always_comb begin
        db_set = '0;
        if (wr_en && (kind == ACC_DOORBELL) && (wdata < DATA_W'(NUM_IRQ))) begin
            db_set[wdata[IDX_W-1:0]] = 1'b1;
        end
    end

endmodule

// File: rtl/agg_cause_bank.sv
module agg_cause_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic              mask_wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] lvl_vec,
    output logic [DATA_W-1:0] cause_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              pend
);
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] cause_d;
    logic [DATA_W-1:0] mask_d;

    assign clr_bits = clr_en ? wdata : '0;

    // ACK beats a level wire (that gives the one-cycle dip); a doorbell beats ACK
    always_comb begin
        cause_d = ((cause_q | lvl_vec) & ~clr_bits) | set_vec;
        mask_d  = mask_wr_en ? wdata : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '1;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
        end
    end

    assign pend = |(cause_q & ~mask_q);

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits & ~set_vec) != '0) |=> ((cause_q & $past(clr_bits & ~set_vec)) == '0)); // R4

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(cause_q & ~clr_bits)) == $past(cause_q & ~clr_bits))); // R5

    AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R6

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_vec & ~clr_bits) != '0) |=> ((cause_q & $past(lvl_vec & ~clr_bits)) == $past(lvl_vec & ~clr_bits))); // R7

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (mask_q == $past(wdata))); // R3

endmodule

// File: rtl/agg_readback.sv
module agg_readback
    import agg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 2
) (
    input  acc_kind_e                         kind,
    input  logic [NUM_REGS-1:0]               reg_sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   cause_all,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   mask_all,
    output logic [DATA_W-1:0]                 rdata
);
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (reg_sel[r]) begin
                case (kind)
                    ACC_CAUSE: rdata = rdata | cause_all[r];
                    ACC_MASK:  rdata = rdata | mask_all[r];
                    default:   rdata = rdata;
                endcase
            end
        end
    end
endmodule

// File: rtl/agg_irq_reduce.sv
module agg_irq_reduce #(
    parameter int NUM_REGS = 2
) (
    input  logic [NUM_REGS-1:0] pend,
    output logic                irq
);
    assign irq = |pend;
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import agg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_IRQ   = 64,
    parameter int NUM_WIRED = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_WIRED-1:0] lvl_src,
    output logic                 irq_out
);
    localparam int NUM_REGS = NUM_IRQ / DATA_W;

    acc_kind_e                         kind;
    logic [NUM_REGS-1:0]               reg_sel;
    logic [NUM_IRQ-1:0]                db_set;
    logic [NUM_IRQ-1:0]                lvl_full;
    logic [NUM_REGS-1:0][DATA_W-1:0]   cause_all;
    logic [NUM_REGS-1:0][DATA_W-1:0]   mask_all;
    logic [NUM_REGS-1:0]               pend;

    // Wired sources occupy the lowest numbers; the rest have no wire
    assign lvl_full = NUM_IRQ'(lvl_src);

    agg_regdecode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_IRQ (NUM_IRQ),
        .NUM_REGS(NUM_REGS)
    ) u_decode (
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .kind   (kind),
        .reg_sel(reg_sel),
        .db_set (db_set)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
        agg_cause_bank #(
            .DATA_W(DATA_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_en    (bus_wr && (kind == ACC_CAUSE) && reg_sel[r]),
            .mask_wr_en(bus_wr && (kind == ACC_MASK) && reg_sel[r]),
            .wdata     (bus_wdata),
            .set_vec   (db_set[r*DATA_W +: DATA_W]),
            .lvl_vec   (lvl_full[r*DATA_W +: DATA_W]),
            .cause_q   (cause_all[r]),
            .mask_q    (mask_all[r]),
            .pend      (pend[r])
        );
    end

    agg_readback #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) u_readback (
        .kind     (kind),
        .reg_sel  (reg_sel),
        .cause_all(cause_all),
        .mask_all (mask_all),
        .rdata    (bus_rdata)
    );

    agg_irq_reduce #(
        .NUM_REGS(NUM_REGS)
    ) u_reduce (
        .pend(pend),
        .irq (irq_out)
    );

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_all) |-> !irq_out); // R3

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|cause_all)); // R8

    AST_DB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(DOORBELL_ADDR)) && (bus_wdata >= DATA_W'(NUM_IRQ))) |-> (db_set == '0)); // R6

endmodule

// File: tb/tb_irq_cause_agg.sv
module tb_irq_cause_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'hFC;
    logic [31:0] bus_wdata = '0;
    logic [20:0] lvl_src = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] ec;   // expected cause bits
    logic [63:0] em;   // expected mask bits

    always #4 clk = ~clk;   // 125 MHz

    irq_cause_agg dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lvl_src  (lvl_src),
        .irq_out  (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 8'hFC;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        rd(8'h00, v); chk(req, v, ec[31:0]);
        rd(8'h04, v); chk(req, v, ec[63:32]);
        rd(8'h20, v); chk(req, v, em[31:0]);
        rd(8'h24, v); chk(req, v, em[63:32]);
        chk(req, 32'(irq_out), 32'(|(ec & ~em)));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        ec = '0;
        em = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_state("R1");

        // R6 / R2 / R4: doorbell every number, exact word and bit, then acknowledge
        for (int n = 0; n < 64; n++) begin
            do_write(8'h30, 32'(n));
            rd(8'((n / 32) * 4), v);
            chk("R6", v, 32'(1) << (n % 32));
            rd(8'(4 - (n / 32) * 4), v);
            chk("R2", v, 32'h0);
            do_write(8'((n / 32) * 4), 32'(1) << (n % 32));
            rd(8'((n / 32) * 4), v);
            chk("R4", v, 32'h0);
        end

        // R3 / R5 / R8: open one mask bit per number
        for (int n = 0; n < 64; n++) begin
            logic [7:0] ma;
            ma = 8'(8'h20 + (n / 32) * 4);
            do_write(8'h30, 32'(n));
            ec[n] = 1'b1;
            #1;
            chk("R5", 32'(irq_out), 32'h0);
            do_write(ma, ~(32'(1) << (n % 32)));
            em[(n / 32) * 32 +: 32] = ~(32'(1) << (n % 32));
            #1;
            chk("R8", 32'(irq_out), 32'h1);
            rd(ma, v);
            chk("R3", v, ~(32'(1) << (n % 32)));
            do_write(ma, 32'hFFFF_FFFF);
            em = '1;
            #1;
            chk("R3", 32'(irq_out), 32'h0);
            rd(8'((n / 32) * 4), v);
            chk("R5", v, 32'(1) << (n % 32));
            do_write(8'((n / 32) * 4), 32'(1) << (n % 32));
            ec[n] = 1'b0;
        end
        check_state("R5");

        // R4: writing zeros keeps pending bits; ones clear them
        do_write(8'h30, 32'd3);
        do_write(8'h30, 32'd40);
        ec[3] = 1'b1; ec[40] = 1'b1;
        do_write(8'h00, 32'h0);
        do_write(8'h04, 32'h0);
        check_state("R4");
        do_write(8'h00, 32'hFFFF_FFFF);
        do_write(8'h04, 32'hFFFF_FFFF);
        ec = '0;
        check_state("R4");

        // R6: out-of-range doorbell values change nothing
        do_write(8'h30, 32'd64);
        do_write(8'h30, 32'd65);
        do_write(8'h30, 32'd127);
        do_write(8'h30, 32'hFFFF_FFFF);
        check_state("R6");

        // R2: unmapped addresses, doorbell readback
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'h2C, 32'h0);
        do_write(8'h08, 32'h0);
        check_state("R2");
        rd(8'h10, v); chk("R2", v, 32'h0);
        rd(8'h30, v); chk("R2", v, 32'h0);

        // R7: level wire, ack dip and re-set
        @(negedge clk);
        lvl_src[5] = 1'b1;
        @(negedge clk);
        rd(8'h00, v); chk("R7", v, 32'h20);
        do_write(8'h00, 32'h20);
        rd(8'h00, v); chk("R7", v, 32'h0);
        @(negedge clk);
        rd(8'h00, v); chk("R7", v, 32'h20);
        lvl_src[5] = 1'b0;
        do_write(8'h00, 32'h20);
        @(negedge clk);
        rd(8'h00, v); chk("R7", v, 32'h0);

        // R7 / R8: highest wired source through an open mask
        do_write(8'h20, ~(32'(1) << 20));
        #1;
        chk("R8", 32'(irq_out), 32'h0);
        @(negedge clk);
        lvl_src[20] = 1'b1;
        @(negedge clk);
        #1;
        chk("R7", 32'(irq_out), 32'h1);
        lvl_src[20] = 1'b0;
        do_write(8'h00, 32'(1) << 20);
        #1;
        chk("R8", 32'(irq_out), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule